// File: doc/BRIEF.md
# Index-Pulse Revolution Sequencer

This block times rotating-media operations against the once-per-revolution index pulse. A controller picks one of four operations and starts it. The block then opens and closes the matching window on index edges. The operations are:

- measuring the rotation period in millisecond ticks;
- enabling flux capture for a chosen number of revolutions;
- erasing exactly one revolution;
- writing exactly one revolution once the data buffer has been primed.

Data buffering, encoding and host transfer are outside the block. It sees only an underrun flag from the buffering logic, and it ends capture or write with an error pulse when that flag rises during the active window. The erase gate has a safety path that needs no help from the state machine: a detected index edge forces the gate low in the same cycle, so the start of the track is never overwritten.

The controller is a single state machine with these states:

| State | Meaning |
|-------|---------|
| `S_IDLE` | Waiting for a start |
| `S_MEAS_ARM` | Measure started, waiting for the first index edge |
| `S_MEAS_RUN` | Counting millisecond ticks until the next index edge |
| `S_CAP_ARM` | Capture started, waiting for the first index edge |
| `S_CAP_RUN` | Capture enabled, revolutions being counted |
| `S_ERS_ARM` | Erase started, waiting for the first index edge |
| `S_ERS_RUN` | Erase gate open |
| `S_WR_PRIME` | Write started, waiting for the primed flag |
| `S_WR_ARM` | Buffer primed, waiting for an index edge |
| `S_WR_RUN` | Writing: erase open, sequencer out of reset |

Its transitions are:

- From `S_IDLE`, a start goes to the ARM state of the selected operation. For write it goes to `S_WR_PRIME` instead.
- `S_WR_PRIME` moves to `S_WR_ARM` when the primed flag is seen.
- Each ARM state moves to its RUN state on an index edge.
- `S_MEAS_RUN` and `S_ERS_RUN` return to `S_IDLE` on the next index edge, with a done pulse.
- `S_CAP_RUN` returns to `S_IDLE` with a done pulse on the edge that ends the last revolution. On an earlier edge it stays and decrements the revolution count.
- `S_CAP_RUN` and `S_WR_RUN` return to `S_IDLE` with an error pulse on an underrun. The underrun takes priority over a simultaneous index edge.
- `S_WR_RUN` returns to `S_IDLE` with a done pulse on an index edge.

Top module: `index_rev_sequencer`

## Requirements
- R1: The index input passes through a two-flop synchroniser and is detected on its rising edge. Each rise counts once however long the input stays high. Registered outputs respond on the third rising clock edge after the raw input goes high.
- R2: A start is accepted only in idle. A start issued while an operation runs changes neither the running operation's outputs nor its revolution count, and it does not alter the measured period.
- R3: Mode 2'b00 (measure) waits for an index edge. It then counts ms_tick pulses until the next index edge, places that count on period_ms, pulses done and holds the value until the next measurement.
- R4: Mode 2'b01 (capture) raises capture_en at the first index edge after the start. It keeps capture_en high for rev_count revolutions and lowers it, with a done pulse, at the rev_count-th later index edge.
- R5: In capture mode, a rev_count of zero at start behaves as one revolution.
- R6: Mode 2'b10 (erase) raises erase_gate at the first index edge after the start. It lowers the gate at the next index edge and pulses done there.
- R7: In every mode, erase_gate is low during any cycle in which an index edge is detected, before the state machine reacts.
- R8: Mode 2'b11 (write) ignores index edges until buf_primed has been seen. At the first index edge after that, it drives erase_gate high and seq_reset low.
- R9: In write mode, the index edge after writing has begun returns seq_reset high, lowers erase_gate and pulses done.
- R10: An underrun while capture_en is high, or while writing, ends the operation: capture_en goes low, or seq_reset goes high and erase_gate low, and err_underrun pulses instead of done. An underrun before the active window has no effect.
- R11: After reset, capture_en, erase_gate, done and err_underrun are low, seq_reset is high and period_ms is zero. done and err_underrun are single-cycle pulses and never both high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| index_in | input | 1 | Raw index pulse, asynchronous |
| ms_tick | input | 1 | One-cycle pulse per millisecond |
| start | input | 1 | Start strobe, accepted in idle only |
| mode | input | 2 | Operation: 00 measure, 01 capture, 10 erase, 11 write |
| rev_count | input | REV_W | Capture revolutions, sampled at start |
| buf_primed | input | 1 | Write buffer is full enough to begin |
| underrun | input | 1 | Buffering logic has run dry |
| capture_en | output | 1 | Capture window open |
| seq_reset | output | 1 | Write sequencer held in reset when high |
| erase_gate | output | 1 | Erase head enable |
| period_ms | output | PERIOD_W | Last measured rotation period |
| done | output | 1 | Operation finished normally (pulse) |
| err_underrun | output | 1 | Operation ended by underrun (pulse) |

## Verification
The hardest case to reach is the cycle where an index edge is detected while the erase register is still high. The erase gate must drop there before the state machine has acted, which the ports only show two clocks after the raw pulse rises. The bench reaches that cycle by driving its own index pulses and sampling erase_gate on the exact detection cycle, during both erase and write windows. It also reaches underruns in the middle of a multi-revolution capture, and starts issued while an operation is busy, by placing those pulses between index pulses at randomly chosen revolutions.

// File: rtl/revseq_pkg.sv
package revseq_pkg;

    typedef enum logic [1:0] {
        OP_MEASURE = 2'd0,
        OP_CAPTURE = 2'd1,
        OP_ERASE   = 2'd2,
        OP_WRITE   = 2'd3
    } op_e;

    typedef enum logic [3:0] {
        S_IDLE,
        S_MEAS_ARM,
        S_MEAS_RUN,
        S_CAP_ARM,
        S_CAP_RUN,
        S_ERS_ARM,
        S_ERS_RUN,
        S_WR_PRIME,
        S_WR_ARM,
        S_WR_RUN
    } state_e;

endpackage

// File: rtl/revseq_index_edge.sv
module revseq_index_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise
);
    logic [STAGES-1:0] sync_q;
    logic              last_q;

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_sync
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[0] <= 1'b0;
                    else        sync_q[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) sync_q[g] <= 1'b0;
                    else        sync_q[g] <= sync_q[g-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= sync_q[STAGES-1];
    end

    assign rise = sync_q[STAGES-1] & ~last_q;

endmodule

// File: rtl/revseq_ms_counter.sv
module revseq_ms_counter #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic         tick,
    output logic [W-1:0] count_next
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    always_comb begin
        if (clear)                         count_next = '0;
        else if (tick && cnt_q != CNT_MAX) count_next = cnt_q + W'(1);
        else                               count_next = cnt_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= count_next;
    end

endmodule

// File: rtl/revseq_rev_counter.sv
module revseq_rev_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         dec,
    output logic         last
);
    logic [W-1:0] left_q;

    always_ff @(posedge clk) begin
        if (!rst_n)              left_q <= '0;
        else if (load)           left_q <= load_val;
        else if (dec && !last)   left_q <= left_q - W'(1);
    end

    assign last = (left_q == W'(1));

endmodule

// File: rtl/index_rev_sequencer.sv
module index_rev_sequencer
    import revseq_pkg::*;
#(
    parameter int PERIOD_W    = 16,
    parameter int REV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                index_in,
    input  logic                ms_tick,
    input  logic                start,
    input  logic [1:0]          mode,
    input  logic [REV_W-1:0]    rev_count,
    input  logic                buf_primed,
    input  logic                underrun,
    output logic                capture_en,
    output logic                seq_reset,
    output logic                erase_gate,
    output logic [PERIOD_W-1:0] period_ms,
    output logic                done,
    output logic                err_underrun
);
    localparam logic [REV_W-1:0] ONE_REV = REV_W'(1);

    state_e state, nxt;
    logic   idx_edge;
    logic   fin_ok, fin_err;
    logic   m_clr, m_latch;
    logic   r_load, r_dec, r_last;
    logic [REV_W-1:0]    load_val;
    logic [PERIOD_W-1:0] cnt_next;

    logic                cap_q, run_q, erase_q, done_q, err_q;
    logic [PERIOD_W-1:0] period_q;

    revseq_index_edge #(.STAGES(SYNC_STAGES)) u_edge (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (index_in),
        .rise     (idx_edge)
    );

    revseq_ms_counter #(.W(PERIOD_W)) u_ms (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (m_clr),
        .tick       (ms_tick),
        .count_next (cnt_next)
    );

    assign load_val = (rev_count == '0) ? ONE_REV : rev_count;

    revseq_rev_counter #(.W(REV_W)) u_rev (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (r_load),
        .load_val (load_val),
        .dec      (r_dec),
        .last     (r_last)
    );

    // Next-state and strobe decode
    always_comb begin
        nxt     = state;
        fin_ok  = 1'b0;
        fin_err = 1'b0;
        m_clr   = 1'b0;
        m_latch = 1'b0;
        r_load  = 1'b0;
        r_dec   = 1'b0;
        unique case (state)
            S_IDLE: begin
                if (start) begin
                    unique case (op_e'(mode))
                        OP_MEASURE: nxt = S_MEAS_ARM;
                        OP_CAPTURE: begin
                            nxt    = S_CAP_ARM;
                            r_load = 1'b1;
                        end
                        OP_ERASE:   nxt = S_ERS_ARM;
                        OP_WRITE:   nxt = S_WR_PRIME;
                        default:    nxt = S_IDLE;
                    endcase
                end
            end
            S_MEAS_ARM: begin
                if (idx_edge) begin
                    nxt   = S_MEAS_RUN;
                    m_clr = 1'b1;
                end
            end
            S_MEAS_RUN: begin
                if (idx_edge) begin
                    nxt     = S_IDLE;
                    m_latch = 1'b1;
                    fin_ok  = 1'b1;
                end
            end
            S_CAP_ARM: begin
                if (idx_edge) nxt = S_CAP_RUN;
            end
            S_CAP_RUN: begin
                if (underrun) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end else if (idx_edge) begin
                    if (r_last) begin
                        nxt    = S_IDLE;
                        fin_ok = 1'b1;
                    end else begin
                        r_dec = 1'b1;
                    end
                end
            end
            S_ERS_ARM: begin
                if (idx_edge) nxt = S_ERS_RUN;
            end
            S_ERS_RUN: begin
                if (idx_edge) begin
                    nxt    = S_IDLE;
                    fin_ok = 1'b1;
                end
            end
            S_WR_PRIME: begin
                if (buf_primed) nxt = S_WR_ARM;
            end
            S_WR_ARM: begin
                if (idx_edge) nxt = S_WR_RUN;
            end
            S_WR_RUN: begin
                if (underrun) begin
                    nxt     = S_IDLE;
                    fin_err = 1'b1;
                end else if (idx_edge) begin
                    nxt    = S_IDLE;
                    fin_ok = 1'b1;
                end
            end
            default: nxt = S_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // Output register, decoded from the state being entered
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cap_q    <= 1'b0;
            run_q    <= 1'b0;
            erase_q  <= 1'b0;
            done_q   <= 1'b0;
            err_q    <= 1'b0;
            period_q <= '0;
        end else begin
            cap_q   <= (nxt == S_CAP_RUN);
            run_q   <= (nxt == S_WR_RUN);
            erase_q <= (nxt == S_ERS_RUN) || (nxt == S_WR_RUN);
            done_q  <= fin_ok;
            err_q   <= fin_err;
            if (m_latch) period_q <= cnt_next;
        end
    end

    assign capture_en   = cap_q;
    assign seq_reset    = ~run_q;
    assign erase_gate   = erase_q & ~idx_edge;   // index kills erase at once
    assign period_ms    = period_q;
    assign done         = done_q;
    assign err_underrun = err_q;

endmodule

// File: rtl/revseq_checker.sv
module revseq_checker (
    input logic clk,
    input logic rst_n,
    input logic idx_edge,
    input logic erase_gate,
    input logic capture_en,
    input logic seq_reset,
    input logic done,
    input logic err_underrun
);
    // R7: a detected index edge never coexists with an open erase gate
    a_r7_gate_low_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
        idx_edge |-> !erase_gate);

    // R6/R8: the erase gate only opens in the cycle after an index edge
    a_r6_erase_opens_after_edge: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(erase_gate) |-> $past(idx_edge));

    // R4/R10: capture closes only with a done or error pulse
    a_r4_capture_close_reported: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(capture_en) |-> (done || err_underrun));

    // R9/R10: the sequencer returns to reset only with a done or error pulse
    a_r9_seq_reset_reported: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(seq_reset) |-> (done || err_underrun));

    // R11: the status pulses are exclusive and last one cycle
    a_r11_status_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err_underrun));

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r11_err_single: assert property (@(posedge clk) disable iff (!rst_n)
        err_underrun |=> !err_underrun);

    // R2: capture and write windows are never open together
    a_r2_one_operation: assert property (@(posedge clk) disable iff (!rst_n)
        !(capture_en && !seq_reset));

endmodule

bind index_rev_sequencer revseq_checker u_revseq_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .idx_edge     (idx_edge),
    .erase_gate   (erase_gate),
    .capture_en   (capture_en),
    .seq_reset    (seq_reset),
    .done         (done),
    .err_underrun (err_underrun)
);

// File: tb/tb_index_rev_sequencer.sv
module tb_index_rev_sequencer;
    localparam int CLK_PERIOD = 10;
    localparam int PW = 16;
    localparam int RW = 8;
    localparam int WATCHDOG = 100000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic index_in = 1'b0, ms_tick = 1'b0, start = 1'b0;
    logic [1:0] mode = 2'd0;
    logic [RW-1:0] rev_count = '0;
    logic buf_primed = 1'b0, underrun = 1'b0;
    logic capture_en, seq_reset, erase_gate, done, err_underrun;
    logic [PW-1:0] period_ms;

    int n_checks = 0, n_fail = 0, cycles = 0, err_cnt = 0;
    bit finished = 0;
    bit g_gate_edge, g_d2, g_d3, g_cap3, g_sr3, g_er3, g_d4;

    always #(CLK_PERIOD/2) clk = ~clk;

    index_rev_sequencer dut (
        .clk(clk), .rst_n(rst_n), .index_in(index_in), .ms_tick(ms_tick),
        .start(start), .mode(mode), .rev_count(rev_count),
        .buf_primed(buf_primed), .underrun(underrun),
        .capture_en(capture_en), .seq_reset(seq_reset), .erase_gate(erase_gate),
        .period_ms(period_ms), .done(done), .err_underrun(err_underrun)
    );

    always @(negedge clk) begin
        cycles++;
        if (err_underrun) err_cnt++;
        if (cycles > WATCHDOG && !finished) begin
            n_fail++;
            $display("FAIL R11 watchdog: cycles %0d expected < %0d", cycles, WATCHDOG);
            $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
            $finish;
        end
    end

    function automatic int exp_revs(input int n);
        return (n == 0) ? 1 : n;
    endfunction

    function automatic int exp_period(input int ticks);
        return (ticks > 65535) ? 65535 : ticks;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Raw index pulse held for 'hold' cycles; records outputs around detection
    task automatic idx(input int hold);
        index_in = 1'b1;
        for (int i = 1; i <= hold + 5; i++) begin
            @(negedge clk);
            if (i == 2) begin g_gate_edge = erase_gate; g_d2 = done; end
            if (i == 3) begin
                g_d3 = done; g_cap3 = capture_en; g_sr3 = seq_reset; g_er3 = erase_gate;
            end
            if (i == 4) g_d4 = done;
            if (i == hold) index_in = 1'b0;
        end
    endtask

    task automatic do_start(input int op, input int cnt);
        start = 1'b1; mode = 2'(op); rev_count = RW'(cnt);
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
    endtask

    task automatic tick_n(input int n);
        for (int k = 0; k < n; k++) begin
            ms_tick = 1'b1; @(negedge clk);
            ms_tick = 1'b0; @(negedge clk);
        end
    endtask

    task automatic pulse_underrun();
        underrun = 1'b1; @(negedge clk);
        underrun = 1'b0;
    endtask

    task automatic run_measure(input int nticks);
        do_start(0, 0);
        idx(3);
        chk(g_d3 == 0, "R3 no done on first edge", g_d3, 0);
        tick_n(nticks);
        idx(3);
        chk(g_d2 == 0 && g_d3 == 1, "R1 R3 done on third clock after index", g_d3, 1);
        chk(g_d4 == 0, "R11 done single cycle", g_d4, 0);
        chk(period_ms == PW'(exp_period(nticks)), "R3 period", period_ms, exp_period(nticks));
    endtask

    task automatic run_capture(input int n, input bit ur, input int ur_at);
        int e0;
        e0 = err_cnt;
        do_start(1, n);
        idx(3);
        chk(g_cap3 == 1 && g_d3 == 0, "R4 capture opens at first edge", g_cap3, 1);
        for (int r = 1; r < exp_revs(n); r++) begin
            if (ur && r == ur_at) begin
                pulse_underrun();
                chk(err_underrun == 1 && capture_en == 0, "R10 capture underrun", err_underrun, 1);
                @(negedge clk);
                chk(err_underrun == 0 && done == 0, "R11 err single cycle", err_underrun, 0);
                return;
            end
            idx(3);
            chk(g_cap3 == 1 && g_d3 == 0, "R4 capture held mid-run", g_cap3, 1);
        end
        idx(3);
        chk(g_d3 == 1 && g_cap3 == 0, n == 0 ? "R5 zero count ends after one rev" : "R4 capture ends",
            g_d3, 1);
        chk(err_cnt == e0, "R10 no error on clean capture", err_cnt, e0);
    endtask

    task automatic run_erase();
        do_start(2, 0);
        chk(erase_gate == 0, "R6 erase closed before edge", erase_gate, 0);
        idx(3);
        chk(g_er3 == 1, "R6 erase opens at first edge", g_er3, 1);
        repeat (4) @(negedge clk);
        chk(erase_gate == 1, "R6 erase held during revolution", erase_gate, 1);
        idx(3);
        chk(g_gate_edge == 0, "R7 erase low on detection cycle", g_gate_edge, 0);
        chk(g_d3 == 1 && g_er3 == 0, "R6 erase closes with done", g_d3, 1);
    endtask

    task automatic run_write(input int prime_delay, input bit ur);
        do_start(3, 0);
        chk(seq_reset == 1 && erase_gate == 0, "R8 write idle before prime", seq_reset, 1);
        idx(3);
        chk(g_sr3 == 1 && g_er3 == 0, "R8 edge before prime ignored", g_sr3, 1);
        pulse_underrun();
        chk(err_underrun == 0 && seq_reset == 1, "R10 underrun before write ignored", err_underrun, 0);
        repeat (prime_delay) @(negedge clk);
        buf_primed = 1'b1; @(negedge clk); buf_primed = 1'b0;
        @(negedge clk);
        chk(seq_reset == 1, "R8 no write before index", seq_reset, 1);
        idx(3);
        chk(g_sr3 == 0 && g_er3 == 1, "R8 write starts at edge", g_sr3, 0);
        if (ur) begin
            pulse_underrun();
            chk(err_underrun == 1 && seq_reset == 1 && erase_gate == 0, "R10 write underrun",
                err_underrun, 1);
            chk(done == 0, "R10 no done on underrun", done, 0);
        end else begin
            idx(3);
            chk(g_gate_edge == 0, "R7 erase low on write end edge", g_gate_edge, 0);
            chk(g_d3 == 1 && g_sr3 == 1 && g_er3 == 0, "R9 write ends at next edge", g_d3, 1);
        end
    endtask

    initial begin
        int p0;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(capture_en == 0 && erase_gate == 0 && done == 0 && err_underrun == 0,
            "R11 reset outputs low", capture_en, 0);
        chk(seq_reset == 1 && period_ms == 0, "R11 reset seq_reset high period zero", seq_reset, 1);

        // Directed corners
        run_measure(7);
        run_measure(0);
        run_capture(0, 0, 0);
        run_capture(3, 0, 0);
        run_erase();
        run_write(2, 0);
        run_write(0, 1);

        // R1: long index pulse counts once
        do_start(1, 2);
        idx(3);
        idx(25);
        chk(g_cap3 == 1 && g_d3 == 0, "R1 long pulse counted once", g_d3, 0);
        repeat (5) @(negedge clk);
        chk(capture_en == 1 && done == 0, "R1 no second count while held", capture_en, 1);
        idx(3);
        chk(g_d3 == 1, "R1 capture ends on next rise", g_d3, 1);

        // R10: underrun while capture armed is ignored
        do_start(1, 1);
        pulse_underrun();
        chk(err_underrun == 0 && capture_en == 0, "R10 underrun in capture arm ignored", err_underrun, 0);
        idx(3);
        chk(g_cap3 == 1, "R10 capture still opens", g_cap3, 1);
        idx(3);
        chk(g_d3 == 1, "R4 single revolution capture", g_d3, 1);

        // R2: start while busy ignored
        p0 = period_ms;
        do_start(1, 2);
        idx(3);
        do_start(0, 0);
        do_start(1, 9);
        idx(3);
        chk(g_cap3 == 1 && g_d3 == 0, "R2 busy start ignored", g_cap3, 1);
        idx(3);
        chk(g_d3 == 1 && g_cap3 == 0, "R2 revolution count unchanged", g_d3, 1);
        chk(period_ms == PW'(p0), "R2 period untouched", period_ms, p0);

        // Constrained random operations
        for (int it = 0; it < 24; it++) begin
            int op;
            op = $urandom_range(0, 3);
            case (op)
                0: run_measure($urandom_range(0, 40));
                1: begin
                    int n;
                    n = $urandom_range(0, 5);
                    run_capture(n, $urandom_range(0, 2) == 0, $urandom_range(1, 4));
                end
                2: run_erase();
                default: run_write($urandom_range(0, 6), $urandom_range(0, 2) == 0);
            endcase
            repeat (3) @(negedge clk);
        end

        finished = 1;
        $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
        $finish;
    end

endmodule